// File: doc/BRIEF.md
# Dual-Channel Prescaled Interval Timer

This block holds a set of identical 16-bit up-counting timer channels. All channels run from one functional clock, but each has its own control, limit and pending state. A channel that is running advances its count once per prescaled period. When the count equals the programmed limit, it sets a pending flag. In auto-reload mode the count then restarts from zero and keeps running. In one-shot mode the channel stops and keeps its count at the limit.

Software reaches the channels through a simple 16-bit register bus. A read returns data in the same cycle as `bus_en`. A write takes effect at the clock edge where `bus_en` and `bus_we` are both high. The bus has no back-pressure, because every access completes in one cycle. Each channel drives one interrupt line, which is high while that channel's flag is pending and its interrupt enable is set. A channel set to auto-reload with a limit of 0xFFFF acts as a free-running timebase.

Top module: `dual_chan_timer`

## Requirements
- R1: Channel k owns the 0x80-byte window starting at byte address 0x80*(k+1). Inside that window, the control register is at +0x0, the status register at +0x4, the limit register at +0x8 and the count register at +0xC. A read of any other address returns 0, and a write to any other address changes nothing.
- R2: The control register holds four fields: interrupt enable at bit 8, run at bit 5, one-shot at bit 4 and a prescaler code at bits [3:0]. These fields read back as written. All other bits read 0, and every register reads 0 after reset.
- R3: A running channel with prescaler code c advances its count once every 2^min(c,8) clock cycles. Codes 9 to 15 therefore divide by 256.
- R4: A write that changes the run bit from 0 to 1 sets both the count and the prescaler divider to zero at that edge. As a result, the first count step comes a full prescaled period later.
- R5: When a count step is due and the count equals the limit, the channel sets its pending flag. In auto-reload mode (bit 4 = 0) the count goes to 0 at that step and the channel keeps running.
- R6: In one-shot mode (bit 4 = 1), the match clears the run bit in hardware and the count stays at the limit value.
- R7: Status bit 0 is the pending flag. Writing 1 to it clears the flag, and writing 0 leaves it unchanged. If a match occurs in the same cycle as a clearing write, the flag stays set.
- R8: irq[k] is high exactly when channel k's flag is pending and its interrupt-enable bit is 1.
- R9: When the run bit is 0, the count holds its value. The limit register may be rewritten at that time, and setting the run bit again starts a new interval.
- R10: The count register is read-only, so a write to it leaves the count unchanged.
- R11: The channels are independent, so an access or an event on one channel changes no register or interrupt of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock shared by all channels |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read (when bus_en) |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as bus_en |
| irq | output | 2 | Per-channel interrupt line |

## Verification
The hardest case to reach from the ports is a match that falls in the same cycle as a software write clearing the flag. To hit that edge, the stimulus counts clock edges exactly from the enabling write and times a second clearing write so that it lands on the second wrap. The same edge-exact counting is used in the divider tests. The channels are stopped and restarted between those tests, so an exact expiry time also shows that the divider was cleared on restart. The divide-by-256 clamp is reached with an out-of-range prescaler code and a limit of zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int WIN_BYTES   = 128;
  localparam int WIN_LSB     = 7;
  localparam int IE_BIT      = 8;
  localparam int RUN_BIT     = 5;
  localparam int ONESHOT_BIT = 4;
  localparam int PS_CODE_W   = 4;
  localparam int PS_MAX      = 8;

  localparam logic [WIN_LSB-1:0] OFF_CTRL  = 7'h00;
  localparam logic [WIN_LSB-1:0] OFF_STAT  = 7'h04;
  localparam logic [WIN_LSB-1:0] OFF_LIMIT = 7'h08;
  localparam logic [WIN_LSB-1:0] OFF_COUNT = 7'h0C;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_LIMIT = 2'd2,
    SEL_COUNT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic                 ie;
    logic                 run;
    logic                 oneshot;
    logic [PS_CODE_W-1:0] ps;
  } ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_CODE_W = 4,
  parameter int PS_MAX    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 restart,
  input  logic [PS_CODE_W-1:0] code,
  output logic                 tick
);

  localparam int DIV_W = PS_MAX;

  logic [DIV_W-1:0]     div_q;
  logic [PS_CODE_W-1:0] eff_code;
  logic [DIV_W:0]       span;
  logic [DIV_W-1:0]     mask;

  // Codes above the maximum saturate at the largest divide ratio.
  always_comb begin
    eff_code = (code > PS_CODE_W'(PS_MAX)) ? PS_CODE_W'(PS_MAX) : code;
    span     = (DIV_W+1)'(1) << eff_code;
    mask     = DIV_W'(span - 1'b1);
  end

  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)      div_q <= '0;
    else if (restart) div_q <= '0;
    else if (run)    div_q <= div_q + 1'b1;
  end

  assert_div_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (div_q == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  limit_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pend_q;

  logic ctrl_wr, stat_wr, limit_wr;
  logic restart, tick, match;

  assign ctrl_wr  = acc && wr && (sel == SEL_CTRL);
  assign stat_wr  = acc && wr && (sel == SEL_STAT);
  assign limit_wr = acc && wr && (sel == SEL_LIMIT);
  assign restart  = ctrl_wr && wdata[RUN_BIT] && !ctrl_q.run;

  tmr_prescaler #(
    .PS_CODE_W (PS_CODE_W),
    .PS_MAX    (PS_MAX)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .restart (restart),
    .code    (ctrl_q.ps),
    .tick    (tick)
  );

  assign match = tick && (cnt_q == limit_q);

  // Control: software write wins; one-shot expiry drops the run bit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.ie      <= wdata[IE_BIT];
      ctrl_q.run     <= wdata[RUN_BIT];
      ctrl_q.oneshot <= wdata[ONESHOT_BIT];
      ctrl_q.ps      <= wdata[PS_CODE_W-1:0];
    end else if (match && ctrl_q.oneshot) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        limit_q <= '0;
    else if (limit_wr) limit_q <= CNT_W'(wdata);
  end

  // Counter: restart to zero, step on tick, wrap or hold on match.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (match) cnt_q <= ctrl_q.oneshot ? cnt_q : '0;
      else       cnt_q <= cnt_q + 1'b1;
    end
  end

  // Pending flag: a new match beats a simultaneous clear.
  always_ff @(posedge clk) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (match)               pend_q <= 1'b1;
    else if (stat_wr && wdata[0]) pend_q <= 1'b0;
  end

  assign irq = pend_q && ctrl_q.ie;

  always_comb begin
    rdata = '0;
    if (acc) begin
      unique case (sel)
        SEL_CTRL: begin
          rdata[IE_BIT]          = ctrl_q.ie;
          rdata[RUN_BIT]         = ctrl_q.run;
          rdata[ONESHOT_BIT]     = ctrl_q.oneshot;
          rdata[PS_CODE_W-1:0]   = ctrl_q.ps;
        end
        SEL_STAT:  rdata[0] = pend_q;
        SEL_LIMIT: rdata    = DATA_W'(limit_q);
        SEL_COUNT: rdata    = DATA_W'(cnt_q);
      endcase
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[DATA_W-1:IE_BIT+1], wdata[IE_BIT-1:RUN_BIT+1]};

  assert_hold_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !ctrl_wr) |=> $stable(cnt_q));

  assert_match_sets_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pend_q);

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !ctrl_q.oneshot && !ctrl_wr) |=> (cnt_q == '0));

  assert_oneshot_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match && ctrl_q.oneshot && !ctrl_wr) |=> (!ctrl_q.run && $stable(cnt_q)));

endmodule

// File: rtl/dual_chan_timer.sv
module dual_chan_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int WIN_W = ADDR_W - WIN_LSB;

  logic [WIN_W-1:0]   win;
  logic [WIN_LSB-1:0] off;
  logic               off_ok;
  reg_sel_e           sel;
  logic [NUM_CH-1:0]  hit;
  logic [DATA_W-1:0]  ch_rdata [NUM_CH];

  assign win = bus_addr[ADDR_W-1:WIN_LSB];
  assign off = bus_addr[WIN_LSB-1:0];

  always_comb begin
    off_ok = 1'b1;
    sel    = SEL_CTRL;
    case (off)
      OFF_CTRL:  sel = SEL_CTRL;
      OFF_STAT:  sel = SEL_STAT;
      OFF_LIMIT: sel = SEL_LIMIT;
      OFF_COUNT: sel = SEL_COUNT;
      default:   off_ok = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign hit[g] = bus_en && off_ok && (win == WIN_W'(g + 1));

    tmr_channel #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
    ) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .acc   (hit[g]),
      .wr    (bus_we),
      .sel   (sel),
      .wdata (bus_wdata),
      .rdata (ch_rdata[g]),
      .irq   (irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) bus_rdata |= ch_rdata[i];
  end

  assert_unmapped_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !(|hit)) |-> (bus_rdata == '0));

  assert_one_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: tb/dual_chan_timer_tb.sv
`timescale 1ns/100ps
module dual_chan_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_chan_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  function automatic logic [8:0] ra(int ch, int off);
    return 9'((ch + 1) * 128 + off);
  endfunction

  localparam int CTRL = 0, STAT = 4, LIM = 8, CNT = 12;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Write: takes effect at the next rising edge, returns after the following falling edge.
  task automatic wr(logic [8:0] a, logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #0.2;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic rchk(string tag, logic [8:0] a, logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rchk("R2 ctrl after reset", ra(0, CTRL), 16'h0000);
    rchk("R2 count after reset", ra(1, CNT), 16'h0000);
    chk("R8 irq after reset", {14'b0, irq}, 16'h0000);
  endtask

  task automatic t_autoreload;
    wr(ra(0, LIM), 16'd2);
    wr(ra(0, CTRL), 16'h0020);
    cyc(2);
    rchk("R3 count steps each cycle", ra(0, CNT), 16'd2);
    rchk("R5 no pending before match", ra(0, STAT), 16'h0000);
    cyc(1);
    rchk("R5 pending at match", ra(0, STAT), 16'h0001);
    rchk("R5 wrap to zero", ra(0, CNT), 16'd0);
    chk("R8 irq low with ie clear", {15'b0, irq[0]}, 16'h0000);
    cyc(1);
    rchk("R5 keeps running", ra(0, CNT), 16'd1);
    wr(ra(0, CTRL), 16'h0000);
    wr(ra(0, STAT), 16'h0001);
  endtask

  task automatic t_prescale;
    wr(ra(0, LIM), 16'd3);
    wr(ra(0, CTRL), 16'h0022);
    cyc(8);
    rchk("R3 divide by 4 count", ra(0, CNT), 16'd2);
    cyc(7);
    rchk("R4 full first interval, no pending", ra(0, STAT), 16'h0000);
    rchk("R3 count at limit", ra(0, CNT), 16'd3);
    cyc(1);
    rchk("R4 pending exactly after 16 cycles", ra(0, STAT), 16'h0001);
    wr(ra(0, CTRL), 16'h0000);
    wr(ra(0, STAT), 16'h0001);
  endtask

  task automatic t_clamp;
    wr(ra(0, LIM), 16'd0);
    wr(ra(0, CTRL), 16'h002C);
    rchk("R2 ctrl readback", ra(0, CTRL), 16'h002C);
    cyc(255);
    rchk("R3 clamp no pending at 255", ra(0, STAT), 16'h0000);
    cyc(1);
    rchk("R3 clamp pending at 256", ra(0, STAT), 16'h0001);
    wr(ra(0, CTRL), 16'h0000);
    wr(ra(0, STAT), 16'h0001);
  endtask

  task automatic t_oneshot;
    wr(ra(0, LIM), 16'd2);
    wr(ra(0, CTRL), 16'h0130);
    cyc(2);
    chk("R8 irq low before match", {15'b0, irq[0]}, 16'h0000);
    cyc(1);
    rchk("R6 pending at match", ra(0, STAT), 16'h0001);
    chk("R8 irq high", {15'b0, irq[0]}, 16'h0001);
    rchk("R6 run bit cleared", ra(0, CTRL), 16'h0110);
    cyc(5);
    rchk("R6 count holds at limit", ra(0, CNT), 16'd2);
    wr(ra(0, STAT), 16'h0000);
    rchk("R7 write 0 keeps pending", ra(0, STAT), 16'h0001);
    wr(ra(0, STAT), 16'h0001);
    rchk("R7 write 1 clears", ra(0, STAT), 16'h0000);
    chk("R8 irq drops", {15'b0, irq[0]}, 16'h0000);
    wr(ra(0, CTRL), 16'h0000);
  endtask

  task automatic t_set_wins;
    wr(ra(0, LIM), 16'd4);
    wr(ra(0, CTRL), 16'h0020);
    cyc(6);
    wr(ra(0, STAT), 16'h0001);
    rchk("R7 clear between matches", ra(0, STAT), 16'h0000);
    cyc(2);
    wr(ra(0, STAT), 16'h0001);
    rchk("R7 match beats clear", ra(0, STAT), 16'h0001);
    wr(ra(0, CTRL), 16'h0000);
    wr(ra(0, STAT), 16'h0001);
  endtask

  task automatic t_stop_restart;
    wr(ra(0, LIM), 16'hFFFF);
    wr(ra(0, CTRL), 16'h0020);
    cyc(5);
    wr(ra(0, CTRL), 16'h0000);
    rchk("R9 stop value", ra(0, CNT), 16'd6);
    cyc(10);
    rchk("R9 count holds while stopped", ra(0, CNT), 16'd6);
    wr(ra(0, CNT), 16'h1234);
    rchk("R10 count is read-only", ra(0, CNT), 16'd6);
    wr(ra(0, LIM), 16'd1);
    rchk("R9 limit rewritten", ra(0, LIM), 16'd1);
    wr(ra(0, CTRL), 16'h0020);
    rchk("R4 restart zeroes count", ra(0, CNT), 16'd0);
    cyc(2);
    rchk("R9 new interval expires", ra(0, STAT), 16'h0001);
    wr(ra(0, CTRL), 16'h0000);
    wr(ra(0, STAT), 16'h0001);
  endtask

  task automatic t_unmapped;
    wr(ra(0, CTRL), 16'h0105);
    wr(ra(0, LIM), 16'h00AA);
    wr(9'h090, 16'hFFFF);
    wr(9'h008, 16'hFFFF);
    wr(9'h182, 16'hFFFF);
    rchk("R1 ctrl untouched by stray writes", ra(0, CTRL), 16'h0105);
    rchk("R1 limit untouched by stray writes", ra(0, LIM), 16'h00AA);
    rchk("R1 read 0x000", 9'h000, 16'h0000);
    rchk("R1 read 0x090", 9'h090, 16'h0000);
    rchk("R1 read 0x082", 9'h082, 16'h0000);
    rchk("R1 read 0x180", 9'h180, 16'h0000);
    wr(ra(0, CTRL), 16'h0000);
  endtask

  task automatic t_independent;
    wr(ra(0, LIM), 16'h0055);
    wr(ra(1, LIM), 16'd1);
    wr(ra(1, CTRL), 16'h0121);
    cyc(3);
    chk("R11 ch1 irq not yet", {15'b0, irq[1]}, 16'h0000);
    cyc(1);
    chk("R11 ch1 irq after 4 cycles", {15'b0, irq[1]}, 16'h0001);
    chk("R11 ch0 irq stays low", {15'b0, irq[0]}, 16'h0000);
    rchk("R11 ch0 limit unchanged", ra(0, LIM), 16'h0055);
    rchk("R11 ch0 count unchanged", ra(0, CNT), 16'd1);
    rchk("R1 ch1 ctrl at 0x100", 9'h100, 16'h0121);
    rchk("R11 ch0 status clear", ra(0, STAT), 16'h0000);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_autoreload();
    t_prescale();
    t_clamp();
    t_oneshot();
    t_set_wins();
    t_stop_restart();
    t_unmapped();
    t_independent();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule